// File: doc/BRIEF.md
# Carry-Select Next-PC Incrementer

This block produces the address of the next sequential instruction from a 32-bit program counter and two decoded length flags: one saying the instruction carries a register-specifier byte, the other saying it carries a 4-byte constant. It is purely combinational. A fetch stage can feed it the selected PC before the instruction bytes have come back from memory.

The counter is split into a 29-bit upper field and a 3-bit lower field. The upper field is incremented speculatively as soon as the PC is known, with no dependence on the instruction length. Only a 3-bit adder on the lower field waits for the length flags. Its carry-out then picks either the incremented or the untouched upper field. The result is the picked upper field joined to the 3-bit sum.

Top module: `pc_seq_incr`

## Requirements
- R1: `next_pc` equals `pc_in` plus the instruction length, modulo 2^32, for every PC value and every flag combination.
- R2: The instruction length is 1 with no flags set, 2 with only `has_regbyte`, 5 with only `has_const`, and 6 with both flags set.
- R3: `next_pc[2:0]` equals (`pc_in[2:0]` + length) modulo 8.
- R4: When `pc_in[2:0]` + length is below 8, `next_pc[31:3]` equals `pc_in[31:3]` unchanged.
- R5: When `pc_in[2:0]` + length is 8 or more, `next_pc[31:3]` equals `pc_in[31:3]` + 1, modulo 2^29.
- R6: The result wraps through zero at the top of the address space. For example, 0xFFFFFFFF with no flags gives 0x00000000, and 0xFFFFFFFC with both flags gives 0x00000002.
- R7: The output follows the inputs with no clock. A change on any input is visible on `next_pc` within the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pc_in | input | 32 | Address of the current instruction |
| has_regbyte | input | 1 | Current instruction carries a register-specifier byte |
| has_const | input | 1 | Current instruction carries a 4-byte constant |
| next_pc | output | 32 | Address of the next sequential instruction |

## Verification
Each of the four flag combinations is applied at an upper-field value with low bits of zero. This separates the length encodings, because no carry can occur there. Low-bit values of 0 to 7 are then swept against all four lengths. That sweep shows which cases keep the upper field and which bump it, and catches a carry mux with its inputs swapped or a carry taken from the wrong position. Upper fields of all ones, with 0xFFFFFFFF as the PC, expose faulty wrap-around. A set of scattered upper fields with long runs of ones checks carry propagation across the chunk boundaries inside the speculative incrementer.

// File: rtl/pc_incr_pkg.sv
package pc_incr_pkg;

    parameter int PC_W    = 32;
    parameter int LO_W    = 3;
    localparam int HI_W   = PC_W - LO_W;
    parameter int CHUNK_W = 8;

    typedef logic [PC_W-1:0] pc_t;
    typedef logic [LO_W-1:0] lo_t;
    typedef logic [HI_W-1:0] hi_t;

    typedef struct packed {
        logic regbyte;
        logic konst;
    } len_flags_t;

    typedef enum logic [1:0] {
        LEN_ONE   = 2'b00,
        LEN_TWO   = 2'b01,
        LEN_FIVE  = 2'b10,
        LEN_SIX   = 2'b11
    } len_kind_t;

    typedef struct packed {
        lo_t  sum;
        logic carry;
    } lo_result_t;

    function automatic len_kind_t classify(input len_flags_t f);
        return len_kind_t'({f.konst, f.regbyte});
    endfunction

    function automatic lo_t kind_to_bytes(input len_kind_t k);
        lo_t b;
        case (k)
            LEN_ONE:  b = lo_t'(1);
            LEN_TWO:  b = lo_t'(2);
            LEN_FIVE: b = lo_t'(5);
            default:  b = lo_t'(6);
        endcase
        return b;
    endfunction

endpackage

// File: rtl/pc_len_encode.sv
module pc_len_encode
    import pc_incr_pkg::*;
(
    input  len_flags_t flags,
    output lo_t        addend
);
    len_kind_t kind;

    always_comb begin
        kind   = classify(flags);
        addend = kind_to_bytes(kind);
    end
endmodule

// File: rtl/pc_low_adder.sv
module pc_low_adder
    import pc_incr_pkg::*;
#(
    parameter int W = LO_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W:0] c;

    assign c[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_fa
        assign sum[i]  = a[i] ^ b[i] ^ c[i];
        assign c[i+1]  = (a[i] & b[i]) | (c[i] & (a[i] ^ b[i]));
    end

    assign cout = c[W];
endmodule

// File: rtl/pc_high_incr.sv
module pc_high_incr
    import pc_incr_pkg::*;
#(
    parameter int W  = HI_W,
    parameter int CW = CHUNK_W
) (
    input  logic [W-1:0] val,
    output logic [W-1:0] val_p1
);
    localparam int NCH   = (W + CW - 1) / CW;
    localparam int PAD_W = NCH * CW;

    logic [PAD_W-1:0] padded;
    logic [PAD_W-1:0] result;
    logic [NCH-1:0]   all_ones;
    logic [NCH:0]     cin;

    assign padded = PAD_W'(val);
    assign cin[0] = 1'b1;

    for (genvar k = 0; k < NCH; k++) begin : g_chunk
        logic [CW-1:0] seg;
        assign seg         = padded[k*CW +: CW];
        assign all_ones[k] = &seg;
        assign cin[k+1]    = cin[k] & all_ones[k];
        assign result[k*CW +: CW] = cin[k] ? seg + CW'(1) : seg;
    end

    assign val_p1 = result[W-1:0];
endmodule

// File: rtl/pc_carry_mux.sv
module pc_carry_mux #(
    parameter int W = 29
) (
    input  logic         sel,
    input  logic [W-1:0] keep,
    input  logic [W-1:0] bump,
    output logic [W-1:0] out
);
    assign out = sel ? bump : keep;
endmodule

// File: rtl/pc_seq_incr.sv
module pc_seq_incr
    import pc_incr_pkg::*;
(
    input  logic [31:0] pc_in,
    input  logic        has_regbyte,
    input  logic        has_const,
    output logic [31:0] next_pc
);
    len_flags_t flags;
    lo_t        addend;
    lo_t        lo_sum;
    logic       lo_carry;
    hi_t        hi_inc;
    hi_t        hi_sel;

    assign flags.regbyte = has_regbyte;
    assign flags.konst   = has_const;

    pc_len_encode u_len (
        .flags  (flags),
        .addend (addend)
    );

    pc_low_adder #(.W(LO_W)) u_lo (
        .a    (pc_in[LO_W-1:0]),
        .b    (addend),
        .sum  (lo_sum),
        .cout (lo_carry)
    );

    pc_high_incr #(.W(HI_W), .CW(CHUNK_W)) u_hi (
        .val    (pc_in[PC_W-1:LO_W]),
        .val_p1 (hi_inc)
    );

    pc_carry_mux #(.W(HI_W)) u_mux (
        .sel  (lo_carry),
        .keep (pc_in[PC_W-1:LO_W]),
        .bump (hi_inc),
        .out  (hi_sel)
    );

    assign next_pc = {hi_sel, lo_sum};
endmodule

// File: rtl/pc_seq_incr_chk.sv
module pc_seq_incr_chk
    import pc_incr_pkg::*;
(
    input logic [31:0] pc_in,
    input logic        has_regbyte,
    input logic        has_const,
    input logic [31:0] next_pc,
    input logic        lo_carry,
    input logic [2:0]  addend
);
    logic [31:0] bytes;
    logic [3:0]  low_total;

    always_comb begin
        bytes     = 32'd1 + (has_regbyte ? 32'd1 : 32'd0) + (has_const ? 32'd4 : 32'd0);
        low_total = {1'b0, pc_in[2:0]} + bytes[3:0];
    end

    always @* begin
        if (!$isunknown({pc_in, has_regbyte, has_const})) begin
            p_sum_r1: assert (next_pc == pc_in + bytes)
                else $error("next_pc mismatch");
            p_len_r2: assert ({29'd0, addend} == bytes)
                else $error("length addend mismatch");
            p_low_r3: assert (next_pc[2:0] == low_total[2:0])
                else $error("low field mismatch");
            p_keep_r4: assert (low_total[3] || next_pc[31:3] == pc_in[31:3])
                else $error("upper field changed without carry");
            p_bump_r5: assert (!low_total[3] || next_pc[31:3] == pc_in[31:3] + 29'd1)
                else $error("upper field not bumped on carry");
            p_carry_r5: assert (lo_carry == low_total[3])
                else $error("low carry mismatch");
        end
    end
endmodule

bind pc_seq_incr pc_seq_incr_chk u_chk (
    .pc_in       (pc_in),
    .has_regbyte (has_regbyte),
    .has_const   (has_const),
    .next_pc     (next_pc),
    .lo_carry    (lo_carry),
    .addend      (addend)
);

// File: tb/tb_pc_seq_incr.sv
module tb_pc_seq_incr;
    logic        clk = 1'b0;
    logic [31:0] pc_in = 32'd0;
    logic        has_regbyte = 1'b0;
    logic        has_const = 1'b0;
    logic [31:0] next_pc;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    pc_seq_incr dut (
        .pc_in       (pc_in),
        .has_regbyte (has_regbyte),
        .has_const   (has_const),
        .next_pc     (next_pc)
    );

    function automatic logic [31:0] len_of(input logic r, input logic c);
        return 32'd1 + (r ? 32'd1 : 32'd0) + (c ? 32'd4 : 32'd0);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [31:0] pc, input logic r, input logic c);
        @(negedge clk);
        pc_in = pc; has_regbyte = r; has_const = c;
        #2;
    endtask

    task automatic t_initial();
        apply(32'd0, 1'b0, 1'b0);
        chk("R1 initial", next_pc, 32'd1);
    endtask

    task automatic t_lengths();
        for (int f = 0; f < 4; f++) begin
            apply(32'h0000_1000, f[0], f[1]);
            chk("R2 length", next_pc - 32'h0000_1000, len_of(f[0], f[1]));
            chk("R4 no carry", {3'b0, next_pc[31:3]}, {3'b0, 29'h0000_0200});
        end
    endtask

    task automatic t_low_sweep();
        for (int lo = 0; lo < 8; lo++) begin
            for (int f = 0; f < 4; f++) begin
                logic [31:0] pc;
                logic [31:0] tot;
                pc  = 32'h1234_5670 | 32'(lo);
                tot = 32'(lo) + len_of(f[0], f[1]);
                apply(pc, f[0], f[1]);
                chk("R3 low field", {29'd0, next_pc[2:0]}, tot & 32'd7);
                if (tot >= 32'd8)
                    chk("R5 carry bump", {3'b0, next_pc[31:3]}, {3'b0, pc[31:3] + 29'd1});
                else
                    chk("R4 keep upper", {3'b0, next_pc[31:3]}, {3'b0, pc[31:3]});
            end
        end
    endtask

    task automatic t_wrap();
        apply(32'hFFFF_FFFF, 1'b0, 1'b0);
        chk("R6 wrap one", next_pc, 32'h0000_0000);
        apply(32'hFFFF_FFFC, 1'b1, 1'b1);
        chk("R6 wrap six", next_pc, 32'h0000_0002);
        apply(32'hFFFF_FFF9, 1'b0, 1'b1);
        chk("R6 no wrap", next_pc, 32'hFFFF_FFFE);
        apply(32'hFFFF_FFFB, 1'b0, 1'b1);
        chk("R6 wrap five", next_pc, 32'h0000_0000);
    endtask

    task automatic t_scatter();
        logic [31:0] seed;
        seed = 32'h1357_9BDF;
        for (int i = 0; i < 200; i++) begin
            logic [31:0] pc;
            seed = seed * 32'd1664525 + 32'd1013904223;
            pc   = seed;
            if (i % 4 == 0) pc = pc | 32'h00FF_FFF8;
            if (i % 4 == 1) pc = pc | 32'h0000_FFF8;
            apply(pc, seed[3], seed[7]);
            chk("R1 sum", next_pc, pc + len_of(seed[3], seed[7]));
        end
    endtask

    task automatic t_comb();
        pc_in = 32'h0000_0007; has_regbyte = 1'b0; has_const = 1'b0;
        #1;
        chk("R7 same cycle", next_pc, 32'h0000_0008);
        has_const = 1'b1;
        #1;
        chk("R7 same cycle", next_pc, 32'h0000_000C);
    endtask

    initial begin
        t_initial();
        t_lengths();
        t_low_sweep();
        t_wrap();
        t_scatter();
        @(posedge clk);
        #3;
        t_comb();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #4000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule